// File: doc/BRIEF.md
# SR-IOV Capability Register File

This block holds the configuration registers of the single-root I/O virtualization extended capability for a PCIe physical function. Software reaches it through a dword port. The address is a dword index counted from the capability base, and each access carries four byte enables. Reads are combinational. A write is accepted on the rising clock edge while `cfg_req_i` and `cfg_we_i` are high.

Some writes have side effects, and the block applies them in the same edge that stores the masked value. A write to the control word that sets the VF enable bit turns on VFs 0 to NumVFs-1, but only if NumVFs is no larger than TotalVFs. Otherwise the enable bit clears itself. A write that clears the enable bit turns every VF off. Any write to the NumVFs field drops the enable bit and turns every VF off. The block drives a per-VF enable vector and the count of VFs that are actually enabled. Consumers use these to gate the virtual functions.

The TotalVFs, InitialVFs, VF offset, VF stride, VF device ID and supported page size values are fixed at elaboration. Each of the six VF BARs has a type and an aperture size set by parameters. From these the block derives the write mask of every BAR dword.

Top module: `sriov_cap_regs`

## Requirements
- R1: After reset, and after any later assertion of `rst_ni`, the block is in this state: control reads 0, NumVFs reads 0, `vf_en_o` and `num_vfs_o` are 0, system page size reads 0x1, and each VF BAR dword reads only its type bits.
- R2: Dword 2 is control in bits [15:0], with status in bits [31:16] reading 0. Only VF enable (bit 0), VF memory space enable (bit 3) and ARI hierarchy (bit 4) are writable, and they are written only when byte enable 0 is set. All other bits read 0.
- R3: When a control write sets bit 0 and NumVFs ≤ TotalVFs, the VF enable bit reads 1 and `vf_en_o` has exactly bits 0..NumVFs-1 set. Both take effect from the edge that accepts the write.
- R4: When a control write sets bit 0 and NumVFs > TotalVFs, the VF enable bit reads 0 and `vf_en_o` is 0.
- R5: A control write with byte enable 0 set and bit 0 clear makes `vf_en_o` 0.
- R6: NumVFs is bits [15:0] of dword 4, with bits [31:16] reading 0. All 16 bits are writable under byte enables 0 and 1. Any write with either of those enables set clears the VF enable bit and makes `vf_en_o` 0.
- R7: `num_vfs_o` equals NumVFs while the VF enable bit is set and is 0 otherwise.
- R8: System page size (dword 8) accepts written bits only where the supported page size mask (default 0x553) is 1, under byte enables.
- R9: VF BAR k sits at dword 9+k. Its writable bits are ~(size-1) and its low bits read the type. A 64-bit memory BAR also makes the next dword fully writable as its upper half, with no type bits. The defaults are: BAR0 64-bit prefetchable memory of 1 MiB (type 0xC), BAR2 32-bit memory of 4 KiB, BAR3 I/O of 256 bytes (type 0x1), and BAR4/5 absent, reading 0.
- R10: The read-only dwords ignore writes. Dword 0 is {next[31:20], version 1, ID 0x0010}. Dword 3 is {TotalVFs, InitialVFs}. Dword 5 is {stride, offset}. Dword 6 is {VF device ID, 0}. Dword 7 is the supported page sizes. Dwords 1 and 15 read 0.
- R11: Writes to dword indices 16 and above change nothing, including the VF enables, and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_req_i | input | 1 | Access strobe |
| cfg_we_i | input | 1 | Write when high |
| cfg_addr_i | input | ADDR_W | Dword index from capability base |
| cfg_be_i | input | 4 | Byte enables of the write |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data for `cfg_addr_i` |
| vf_en_o | output | TOTAL_VFS | Per-VF enable |
| num_vfs_o | output | 16 | Count of enabled VFs |

## Verification
A corrupted VF enable bit or NumVFs register appears at `num_vfs_o` and in the count of ones of `vf_en_o`, starting with the cycle after the write that caused it. A wrong mask or a lost type bit appears in the readback of the dword that was just written. The bench reads every dword after each directed step and reads back the addressed dword after every random write. A wrong state is therefore reported within one access of being created.

// File: rtl/sriov_pkg.sv
package sriov_pkg;
  localparam int unsigned NUM_BARS = 6;
  localparam int unsigned CAP_DWORDS = 16;

  localparam logic [3:0] DW_HDR  = 4'd0;
  localparam logic [3:0] DW_CTRL = 4'd2;
  localparam logic [3:0] DW_VFS  = 4'd3;
  localparam logic [3:0] DW_NUM  = 4'd4;
  localparam logic [3:0] DW_ROUT = 4'd5;
  localparam logic [3:0] DW_DID  = 4'd6;
  localparam logic [3:0] DW_SUPP = 4'd7;
  localparam logic [3:0] DW_PGSZ = 4'd8;
  localparam logic [3:0] DW_BAR0 = 4'd9;

  localparam int unsigned VFE_BIT = 0;
  localparam int unsigned MSE_BIT = 3;
  localparam int unsigned ARI_BIT = 4;

  localparam logic [15:0] CAP_ID = 16'h0010;
  localparam logic [3:0]  CAP_VER = 4'h1;

  function automatic logic [31:0] be_mask(input logic [3:0] be);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{be[i]}};
    return m;
  endfunction

  function automatic logic bar_is_wide(input logic [3:0] ty, input logic [5:0] sz);
    return (sz != 6'd0) && !ty[0] && (ty[2:1] == 2'b10);
  endfunction

  // true when BAR i is the upper dword of a 64-bit BAR below it
  function automatic logic bar_is_hi(input logic [NUM_BARS-1:0][3:0] ty,
                                     input logic [NUM_BARS-1:0][5:0] sz, input int i);
    logic nxt = 1'b0;
    for (int j = 0; j < i; j++) nxt = nxt ? 1'b0 : bar_is_wide(ty[j], sz[j]);
    return nxt;
  endfunction

  function automatic logic [31:0] bar_wmask(input logic [NUM_BARS-1:0][3:0] ty,
                                            input logic [NUM_BARS-1:0][5:0] sz, input int i);
    logic [63:0] m;
    if (bar_is_hi(ty, sz, i)) begin
      m = ~((64'd1 << sz[i-1]) - 64'd1);
      return m[63:32];
    end
    if (sz[i] == 6'd0) return 32'h0;
    m = ~((64'd1 << sz[i]) - 64'd1);
    return m[31:0];
  endfunction

  function automatic logic [31:0] bar_type(input logic [NUM_BARS-1:0][3:0] ty,
                                           input logic [NUM_BARS-1:0][5:0] sz, input int i);
    if (bar_is_hi(ty, sz, i) || sz[i] == 6'd0) return 32'h0;
    return {28'h0, ty[i]};
  endfunction
endpackage

// File: rtl/sriov_vf_ctrl.sv
module sriov_vf_ctrl #(
  parameter int unsigned TOTAL_VFS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ctrl_wr_i,
  input  logic [7:0]           ctrl_byte_i,
  input  logic                 num_wr_i,
  input  logic [1:0]           num_be_i,
  input  logic [15:0]          num_data_i,
  output logic                 vfe_o,
  output logic                 mse_o,
  output logic                 ari_o,
  output logic [15:0]          num_q_o,
  output logic [TOTAL_VFS-1:0] vf_en_o
);
  localparam logic [15:0] TotalW = 16'(TOTAL_VFS);

  logic [TOTAL_VFS-1:0] thermo;

  always_comb begin
    for (int i = 0; i < TOTAL_VFS; i++) thermo[i] = (32'(i) < {16'h0, num_q_o});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vfe_o   <= 1'b0;
      mse_o   <= 1'b0;
      ari_o   <= 1'b0;
      num_q_o <= '0;
      vf_en_o <= '0;
    end else if (ctrl_wr_i) begin
      mse_o <= ctrl_byte_i[sriov_pkg::MSE_BIT];
      ari_o <= ctrl_byte_i[sriov_pkg::ARI_BIT];
      if (ctrl_byte_i[sriov_pkg::VFE_BIT] && num_q_o <= TotalW) begin
        vfe_o   <= 1'b1;
        vf_en_o <= thermo;
      end else begin
        vfe_o   <= 1'b0;
        vf_en_o <= '0;
      end
    end else if (num_wr_i) begin
      if (num_be_i[0]) num_q_o[7:0]  <= num_data_i[7:0];
      if (num_be_i[1]) num_q_o[15:8] <= num_data_i[15:8];
      vfe_o   <= 1'b0;
      vf_en_o <= '0;
    end
  end
endmodule

// File: rtl/sriov_vf_bars.sv
module sriov_vf_bars #(
  parameter logic [sriov_pkg::NUM_BARS-1:0][3:0] BAR_TYPE    = '0,
  parameter logic [sriov_pkg::NUM_BARS-1:0][5:0] BAR_SZ_LOG2 = '0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [3:0]  idx_i,
  input  logic [3:0]  be_i,
  input  logic [31:0] wdata_i,
  output logic [sriov_pkg::NUM_BARS-1:0][31:0] rd_o
);
  logic [31:0] byte_m;
  assign byte_m = sriov_pkg::be_mask(be_i);

  for (genvar g = 0; g < sriov_pkg::NUM_BARS; g++) begin : g_bar
    localparam logic [31:0] WMask   = sriov_pkg::bar_wmask(BAR_TYPE, BAR_SZ_LOG2, g);
    localparam logic [31:0] TypeBit = sriov_pkg::bar_type(BAR_TYPE, BAR_SZ_LOG2, g);
    logic [31:0] q;
    logic [31:0] wbits;
    assign wbits = WMask & byte_m;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (wr_i && idx_i == sriov_pkg::DW_BAR0 + 4'(g)) q <= (q & ~wbits) | (wdata_i & wbits);
    end
    assign rd_o[g] = q | TypeBit;
  end
endmodule

// File: rtl/sriov_cap_regs.sv
module sriov_cap_regs #(
  parameter int unsigned TOTAL_VFS  = 8,
  parameter int unsigned INIT_VFS   = 8,
  parameter logic [15:0] VF_OFFSET  = 16'd1,
  parameter logic [15:0] VF_STRIDE  = 16'd1,
  parameter logic [15:0] VF_DEV_ID  = 16'hA5C1,
  parameter logic [31:0] SUP_PGSIZE = 32'h0000_0553,
  parameter logic [11:0] CAP_NEXT   = 12'h000,
  parameter int unsigned ADDR_W     = 10,
  parameter logic [sriov_pkg::NUM_BARS-1:0][3:0] BAR_TYPE =
    {4'h0, 4'h0, 4'h1, 4'h0, 4'h0, 4'hC},
  parameter logic [sriov_pkg::NUM_BARS-1:0][5:0] BAR_SZ_LOG2 =
    {6'd0, 6'd0, 6'd8, 6'd12, 6'd0, 6'd20}
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_req_i,
  input  logic                 cfg_we_i,
  input  logic [ADDR_W-1:0]    cfg_addr_i,
  input  logic [3:0]           cfg_be_i,
  input  logic [31:0]          cfg_wdata_i,
  output logic [31:0]          cfg_rdata_o,
  output logic [TOTAL_VFS-1:0] vf_en_o,
  output logic [15:0]          num_vfs_o
);
  import sriov_pkg::*;

  localparam logic [15:0] TotalW = 16'(TOTAL_VFS);
  localparam logic [15:0] InitW  = 16'(INIT_VFS);

  logic        in_cap, wr;
  logic [3:0]  idx;
  logic        vfe, mse, ari;
  logic [15:0] num_q;
  logic [31:0] pgsz_q, pg_bits;
  logic [NUM_BARS-1:0][31:0] bar_rd;

  assign in_cap = {{(32-ADDR_W){1'b0}}, cfg_addr_i} < 32'(CAP_DWORDS);
  assign idx    = cfg_addr_i[3:0];
  assign wr     = cfg_req_i & cfg_we_i & in_cap;

  sriov_vf_ctrl #(.TOTAL_VFS(TOTAL_VFS)) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_wr_i  (wr && idx == DW_CTRL && cfg_be_i[0]),
    .ctrl_byte_i(cfg_wdata_i[7:0]),
    .num_wr_i   (wr && idx == DW_NUM && |cfg_be_i[1:0]),
    .num_be_i   (cfg_be_i[1:0]),
    .num_data_i (cfg_wdata_i[15:0]),
    .vfe_o      (vfe),
    .mse_o      (mse),
    .ari_o      (ari),
    .num_q_o    (num_q),
    .vf_en_o    (vf_en_o)
  );

  sriov_vf_bars #(.BAR_TYPE(BAR_TYPE), .BAR_SZ_LOG2(BAR_SZ_LOG2)) i_bars (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr),
    .idx_i  (idx),
    .be_i   (cfg_be_i),
    .wdata_i(cfg_wdata_i),
    .rd_o   (bar_rd)
  );

  assign pg_bits = SUP_PGSIZE & be_mask(cfg_be_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pgsz_q <= 32'h1;
    else if (wr && idx == DW_PGSZ) pgsz_q <= (pgsz_q & ~pg_bits) | (cfg_wdata_i & pg_bits);
  end

  assign num_vfs_o = vfe ? num_q : 16'h0;

  always_comb begin
    cfg_rdata_o = 32'h0;
    if (in_cap) begin
      unique case (idx)
        DW_HDR:  cfg_rdata_o = {CAP_NEXT, CAP_VER, CAP_ID};
        DW_CTRL: cfg_rdata_o = 32'({ari, mse, 2'b00, vfe});
        DW_VFS:  cfg_rdata_o = {TotalW, InitW};
        DW_NUM:  cfg_rdata_o = {16'h0, num_q};
        DW_ROUT: cfg_rdata_o = {VF_STRIDE, VF_OFFSET};
        DW_DID:  cfg_rdata_o = {VF_DEV_ID, 16'h0};
        DW_SUPP: cfg_rdata_o = SUP_PGSIZE;
        DW_PGSZ: cfg_rdata_o = pgsz_q;
        4'd9:    cfg_rdata_o = bar_rd[0];
        4'd10:   cfg_rdata_o = bar_rd[1];
        4'd11:   cfg_rdata_o = bar_rd[2];
        4'd12:   cfg_rdata_o = bar_rd[3];
        4'd13:   cfg_rdata_o = bar_rd[4];
        4'd14:   cfg_rdata_o = bar_rd[5];
        default: cfg_rdata_o = 32'h0;
      endcase
    end
  end
endmodule

// File: rtl/sriov_cap_regs_chk.sv
module sriov_cap_regs_chk #(
  parameter int unsigned TOTAL_VFS = 8,
  parameter int unsigned ADDR_W    = 10
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cfg_req_i,
  input logic                 cfg_we_i,
  input logic [ADDR_W-1:0]    cfg_addr_i,
  input logic [3:0]           cfg_be_i,
  input logic [31:0]          cfg_wdata_i,
  input logic [31:0]          cfg_rdata_o,
  input logic [TOTAL_VFS-1:0] vf_en_o,
  input logic [15:0]          num_vfs_o
);
  logic wr, outside;
  assign wr      = cfg_req_i & cfg_we_i;
  assign outside = {{(32-ADDR_W){1'b0}}, cfg_addr_i} >= 32'd16;

  // R3
  vf_en_contig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((vf_en_o + 1'b1) & vf_en_o) == '0);

  // R7
  vf_count_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(vf_en_o) == int'(num_vfs_o));

  // R4
  vf_count_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(num_vfs_o) <= int'(TOTAL_VFS));

  // R5
  vfe_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && !outside && cfg_addr_i[3:0] == 4'd2 && cfg_be_i[0] && !cfg_wdata_i[0])
      |=> (vf_en_o == '0 && num_vfs_o == 16'h0));

  // R6
  num_write_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && !outside && cfg_addr_i[3:0] == 4'd4 && |cfg_be_i[1:0])
      |=> (vf_en_o == '0 && num_vfs_o == 16'h0));

  // R11
  outside_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && outside) |=> ($stable(vf_en_o) && $stable(num_vfs_o)));

  // R11
  outside_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    outside |-> cfg_rdata_o == 32'h0);

  // R2
  ctrl_ro_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!outside && cfg_addr_i[3:0] == 4'd2) |-> (cfg_rdata_o[31:5] == '0 && cfg_rdata_o[2:1] == 2'b00));
endmodule

bind sriov_cap_regs sriov_cap_regs_chk #(.TOTAL_VFS(TOTAL_VFS), .ADDR_W(ADDR_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_req_i  (cfg_req_i),
  .cfg_we_i   (cfg_we_i),
  .cfg_addr_i (cfg_addr_i),
  .cfg_be_i   (cfg_be_i),
  .cfg_wdata_i(cfg_wdata_i),
  .cfg_rdata_o(cfg_rdata_o),
  .vf_en_o    (vf_en_o),
  .num_vfs_o  (num_vfs_o)
);

// File: tb/test_sriov_cap_regs.sv
module test_sriov_cap_regs;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_req_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [9:0]  cfg_addr_i = '0;
  logic [3:0]  cfg_be_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic [7:0]  vf_en_o;
  logic [15:0] num_vfs_o;

  int n_run = 0;
  int n_fail = 0;

  // bench model
  logic        m_vfe, m_mse, m_ari;
  logic [15:0] m_num;
  logic [31:0] m_pg;
  logic [31:0] m_bar [6];
  localparam logic [31:0] BMASK [6] = '{32'hFFF0_0000, 32'hFFFF_FFFF, 32'hFFFF_F000,
                                        32'hFFFF_FF00, 32'h0, 32'h0};
  localparam logic [31:0] BTYPE [6] = '{32'hC, 32'h0, 32'h0, 32'h1, 32'h0, 32'h0};

  sriov_cap_regs i_sriov_cap_regs (.*);

  always #5ns clk_i = ~clk_i;

  function automatic logic [31:0] bm(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  function automatic string tag_of(input int a);
    if (a >= 16) return "R11";
    case (a)
      2: return "R2";
      4: return "R6";
      8: return "R8";
      9, 10, 11, 12, 13, 14: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(input int a);
    if (a >= 16) return 32'h0;
    case (a)
      0: return 32'h0001_0010;
      2: return {27'h0, m_ari, m_mse, 2'b00, m_vfe};
      3: return {16'd8, 16'd8};
      4: return {16'h0, m_num};
      5: return {16'd1, 16'd1};
      6: return {16'hA5C1, 16'h0};
      7: return 32'h553;
      8: return m_pg;
      9, 10, 11, 12, 13, 14: return m_bar[a-9] | BTYPE[a-9];
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [7:0] exp_en();
    return m_vfe ? 8'((16'h1 << m_num) - 16'h1) : 8'h0;
  endfunction

  task automatic model_reset();
    m_vfe = 0; m_mse = 0; m_ari = 0; m_num = 0; m_pg = 32'h1;
    for (int i = 0; i < 6; i++) m_bar[i] = 32'h0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input int a, input string req);
    @(negedge clk_i);
    cfg_req_i = 1; cfg_we_i = 0; cfg_addr_i = 10'(a);
    #1;
    chk(req, cfg_rdata_o, exp_rd(a));
    cfg_req_i = 0;
  endtask

  task automatic chk_outs();
    chk("R3", 32'(vf_en_o), 32'(exp_en()));
    chk("R7", 32'(num_vfs_o), m_vfe ? 32'(m_num) : 32'h0);
  endtask

  task automatic check_all(input string req);
    chk_outs();
    for (int a = 0; a < 16; a++) rd_chk(a, req);
  endtask

  task automatic wr(input int a, input logic [3:0] be, input logic [31:0] d);
    logic [31:0] m;
    @(negedge clk_i);
    cfg_req_i = 1; cfg_we_i = 1; cfg_addr_i = 10'(a); cfg_be_i = be; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_req_i = 0; cfg_we_i = 0;
    m = bm(be);
    if (a == 2 && be[0]) begin
      m_mse = d[3]; m_ari = d[4];
      m_vfe = d[0] && (m_num <= 16'd8);
    end else if (a == 4 && |be[1:0]) begin
      m_num = (m_num & ~m[15:0]) | (d[15:0] & m[15:0]);
      m_vfe = 0;
    end else if (a == 8) begin
      m = m & 32'h553;
      m_pg = (m_pg & ~m) | (d & m);
    end else if (a >= 9 && a <= 14) begin
      m = m & BMASK[a-9];
      m_bar[a-9] = (m_bar[a-9] & ~m) | (d & m);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 0;
    model_reset();
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0A11));
    do_reset();
    check_all("R1");

    // R3: three VFs with all writable control bits
    wr(4, 4'b0011, 32'h3);
    wr(2, 4'b0001, 32'h19);
    check_all("R3");
    // R2: non-writable control bits stay zero
    wr(2, 4'b0001, 32'hFFFF_FFFF);
    rd_chk(2, "R2");
    chk_outs();
    // R2: control ignored without byte enable 0
    wr(2, 4'b1110, 32'h0);
    rd_chk(2, "R2");
    chk("R2", 32'(vf_en_o), 32'h1F & 32'h07);
    // R6: writing only the upper NumVFs byte still drops enable
    wr(4, 4'b0010, 32'h0);
    check_all("R6");
    // R4: count above total
    wr(4, 4'b0011, 32'h9);
    wr(2, 4'b0001, 32'h1);
    chk("R4", 32'(vf_en_o), 32'h0);
    rd_chk(2, "R4");
    // R3: boundary at total and at zero
    wr(4, 4'b0011, 32'h8);
    wr(2, 4'b0001, 32'h1);
    chk("R3", 32'(vf_en_o), 32'hFF);
    wr(4, 4'b0011, 32'h0);
    wr(2, 4'b0001, 32'h1);
    chk("R7", 32'(num_vfs_o), 32'h0);
    rd_chk(2, "R3");
    // R5: clearing enable
    wr(4, 4'b0011, 32'h5);
    wr(2, 4'b0001, 32'h1);
    chk("R3", 32'(vf_en_o), 32'h1F);
    wr(2, 4'b0001, 32'h0);
    chk("R5", 32'(vf_en_o), 32'h0);
    // R11: writes outside change nothing
    wr(2, 4'b0001, 32'h1);
    wr(18, 4'hF, 32'hFFFF_FFFF);
    wr(16, 4'hF, 32'h0);
    chk("R11", 32'(vf_en_o), 32'h1F);
    rd_chk(18, "R11");
    check_all("R11");
    // R8: page size mask
    wr(8, 4'hF, 32'hFFFF_FFFF);
    chk("R8", exp_rd(8), 32'h553);
    rd_chk(8, "R8");
    wr(8, 4'b0001, 32'h0);
    rd_chk(8, "R8");
    // R9: BAR masks and types
    for (int a = 9; a < 15; a++) wr(a, 4'hF, 32'hFFFF_FFFF);
    for (int a = 9; a < 15; a++) rd_chk(a, "R9");
    // R10: read-only dwords
    for (int a = 0; a < 16; a++) if (tag_of(a) == "R10") wr(a, 4'hF, 32'h1234_5678);
    check_all("R10");
    // R1: reset mid-operation
    do_reset();
    check_all("R1");

    for (int n = 0; n < 600; n++) begin
      int a;
      logic [31:0] d;
      logic [3:0] be;
      a = ($urandom % 4 == 0) ? int'(16 + $urandom % 20) : int'($urandom % 16);
      d = $urandom;
      be = 4'($urandom);
      if (a == 4 && ($urandom % 4 != 0)) d = d & 32'hF;
      if (a == 2 && ($urandom % 2 == 0)) d[0] = 1'b1;
      wr(a, be, d);
      chk_outs();
      rd_chk(a, tag_of(a));
      if (n % 97 == 0) do_reset();
    end
    check_all("R1");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule